// File: doc/BRIEF.md
# Flag Word and Condition Evaluator

This block keeps the 16-bit control-and-flag word of a processor core and answers, every cycle, whether a 4-bit branch condition holds against the stored flags. The upper byte carries mode and interrupt-enable controls. The lower byte carries the arithmetic flags that an ALU produces. Several bits have no function and are kept at zero.

The word can change in three ways: a full-word load, a masked write of the low-byte flags from the ALU, and per-bit set and clear strobes. The strobes include a grouped-clear selector for the common flag groups. When several of these are active in the same cycle, only the highest-priority one acts.

The condition output is combinational from the registered word. The sixteen codes cover signed and unsigned comparisons. They are built from sign-xor-overflow and zero-or-carry terms. The upper eight codes are exact complements of the lower eight.

Top module: `flag_word_unit`

## Requirements
- R1: After reset the word equals the RESET_WORD parameter with the unused bits (10, 9, 8, 1, 0) cleared.
- R2: Bits 10, 9, 8, 1 and 0 of word_o read as zero at all times, whatever value any update source writes.
- R3: With load_en_i high, the next word is load_word_i with the unused bits cleared. The ALU bus and the strobes are ignored in that cycle.
- R4: With load_en_i low and any alu_mask_i bit set, each masked bit of word_o[7:0] takes the matching bit of alu_flags_i. All other bits hold, and the set, clear and group strobes are ignored in that cycle.
- R5: With no load and a zero ALU mask, each set_i bit sets and each clr_i bit clears the same word bit. Set wins when both strobes hit one bit. With no strobe active the word holds.
- R6: grp_clr_i clears flag groups: 1 = carry, zero, sign; 2 = those plus parity/overflow; 3 = those plus half-carry; 4 = zero, sign; 5 = zero, sign, parity/overflow. Codes 0, 6 and 7 clear nothing.
- R7: Flag positions are carry 7, zero 6, sign 5, parity/overflow 4, decimal-adjust 3, half-carry 2. Parity and overflow are one shared bit, so a write of either affects bit 4 only. carry_o, zero_o, sign_o, pv_o, da_o and hc_o mirror those bits.
- R8: Codes 0 to 7 give: 0 never; 1 S xor V; 2 Z or (S xor V); 3 Z or C; 4 V; 5 S; 6 Z; 7 C.
- R9: Code 8 is always true, and codes 9 to 15 are the inverse of codes 1 to 7 in the same order.
- R10: cc_true_o follows cc_i in the same cycle and reflects a word update from the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_en_i | input | 1 | Full-word load strobe |
| load_word_i | input | 16 | Value for full-word load |
| alu_mask_i | input | 8 | Per-bit write mask for the low byte from the ALU |
| alu_flags_i | input | 8 | Flag values from the ALU |
| set_i | input | 16 | Per-bit set strobes |
| clr_i | input | 16 | Per-bit clear strobes |
| grp_clr_i | input | 3 | Grouped-clear selector |
| cc_i | input | 4 | Condition code to evaluate |
| word_o | output | 16 | Current control-and-flag word |
| carry_o | output | 1 | Carry flag |
| zero_o | output | 1 | Zero flag |
| sign_o | output | 1 | Sign flag |
| pv_o | output | 1 | Parity/overflow flag |
| da_o | output | 1 | Decimal-adjust flag (0 add, 1 subtract) |
| hc_o | output | 1 | Half-carry flag |
| cc_true_o | output | 1 | Condition result |

## Verification
The bench builds the block with RESET_WORD = 16'h4703. This value sets system mode and also sets bits in every unused field, so the reset check covers both the parameter path and the forcing of unused bits to zero. All 64 combinations of the six low-byte flags are loaded and checked against every condition code. This exposes any swapped term in the signed and unsigned comparisons and any code whose complement is wrong.

// File: rtl/fw_pkg.sv
package fw_pkg;
  localparam int WORD_W = 16;
  localparam int CC_W   = 4;
  localparam int ALU_W  = 8;
  localparam int GRP_W  = 3;

  localparam int B_SEG  = 15;
  localparam int B_SYS  = 14;
  localparam int B_EXT  = 13;
  localparam int B_VIE  = 12;
  localparam int B_NVIE = 11;
  localparam int B_C    = 7;
  localparam int B_Z    = 6;
  localparam int B_S    = 5;
  localparam int B_PV   = 4;
  localparam int B_DA   = 3;
  localparam int B_H    = 2;

  localparam logic [WORD_W-1:0] USED_MASK = WORD_W'(
      (1 << B_SEG) | (1 << B_SYS) | (1 << B_EXT) | (1 << B_VIE) | (1 << B_NVIE) |
      (1 << B_C) | (1 << B_Z) | (1 << B_S) | (1 << B_PV) | (1 << B_DA) | (1 << B_H));

  typedef enum logic [GRP_W-1:0] {
    GC_NONE  = 3'd0,
    GC_CZS   = 3'd1,
    GC_CZSV  = 3'd2,
    GC_CZSVH = 3'd3,
    GC_ZS    = 3'd4,
    GC_ZSV   = 3'd5
  } grp_clr_e;

  function automatic logic [WORD_W-1:0] grp_mask(input logic [GRP_W-1:0] sel);
    logic [WORD_W-1:0] m;
    m = '0;
    case (sel)
      GC_CZS:   begin m[B_C] = 1'b1; m[B_Z] = 1'b1; m[B_S] = 1'b1; end
      GC_CZSV:  begin m[B_C] = 1'b1; m[B_Z] = 1'b1; m[B_S] = 1'b1; m[B_PV] = 1'b1; end
      GC_CZSVH: begin m[B_C] = 1'b1; m[B_Z] = 1'b1; m[B_S] = 1'b1; m[B_PV] = 1'b1;
                      m[B_H] = 1'b1; end
      GC_ZS:    begin m[B_Z] = 1'b1; m[B_S] = 1'b1; end
      GC_ZSV:   begin m[B_Z] = 1'b1; m[B_S] = 1'b1; m[B_PV] = 1'b1; end
      default:  m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/fw_strobe_merge.sv
module fw_strobe_merge
  import fw_pkg::*;
(
  input  logic [WORD_W-1:0] set_i,
  input  logic [WORD_W-1:0] clr_i,
  input  logic [GRP_W-1:0]  grp_clr_i,
  output logic [WORD_W-1:0] set_vec_o,
  output logic [WORD_W-1:0] clr_vec_o
);
  logic [WORD_W-1:0] grp_vec;

  always_comb begin
    grp_vec   = grp_mask(grp_clr_i);
    set_vec_o = set_i & USED_MASK;
    // set wins: drop clears where a set is present
    clr_vec_o = (clr_i | grp_vec) & USED_MASK & ~set_vec_o;
  end
endmodule

// File: rtl/fw_word_reg.sv
module fw_word_reg
  import fw_pkg::*;
#(
  parameter logic [WORD_W-1:0] RESET_WORD = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_en_i,
  input  logic [WORD_W-1:0] load_word_i,
  input  logic [ALU_W-1:0]  alu_mask_i,
  input  logic [ALU_W-1:0]  alu_flags_i,
  input  logic [WORD_W-1:0] set_vec_i,
  input  logic [WORD_W-1:0] clr_vec_i,
  output logic [WORD_W-1:0] word_o
);
  localparam logic [WORD_W-1:0] RST_VAL = RESET_WORD & USED_MASK;

  logic [WORD_W-1:0] word_q, word_d;
  logic              alu_act;

  assign alu_act = |alu_mask_i;

  always_comb begin
    word_d = word_q;
    if (load_en_i) begin
      word_d = load_word_i;
    end else if (alu_act) begin
      word_d[ALU_W-1:0] = (word_q[ALU_W-1:0] & ~alu_mask_i) | (alu_flags_i & alu_mask_i);
    end else begin
      word_d = (word_q & ~clr_vec_i) | set_vec_i;
    end
    word_d = word_d & USED_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_q <= RST_VAL;
    else         word_q <= word_d;
  end

  assign word_o = word_q;

  a_r2_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_q & ~USED_MASK) == '0);

  a_r3_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en_i |=> word_q == ($past(load_word_i) & USED_MASK));

  a_r4_alu_merge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_en_i && alu_act) |=>
      (word_q[WORD_W-1:ALU_W] == $past(word_q[WORD_W-1:ALU_W])) &&
      (((word_q[ALU_W-1:0] ^ $past(alu_flags_i)) & $past(alu_mask_i) & USED_MASK[ALU_W-1:0]) == '0));

  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_en_i && !alu_act && set_vec_i == '0 && clr_vec_i == '0) |=> $stable(word_q));
endmodule

// File: rtl/fw_cond_eval.sv
module fw_cond_eval
  import fw_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic [CC_W-1:0]   cc_i,
  output logic              cc_true_o
);
  logic c, z, s, v, lt, base;

  always_comb begin
    c  = word_i[B_C];
    z  = word_i[B_Z];
    s  = word_i[B_S];
    v  = word_i[B_PV];
    lt = s ^ v;
    case (cc_i[CC_W-2:0])
      3'd0: base = 1'b0;
      3'd1: base = lt;
      3'd2: base = z | lt;
      3'd3: base = z | c;
      3'd4: base = v;
      3'd5: base = s;
      3'd6: base = z;
      default: base = c;
    endcase
    // upper half is the complement of the lower half
    cc_true_o = cc_i[CC_W-1] ^ base;
  end
endmodule

// File: rtl/flag_word_unit.sv
module flag_word_unit
  import fw_pkg::*;
#(
  parameter logic [15:0] RESET_WORD = 16'h0000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_en_i,
  input  logic [15:0] load_word_i,
  input  logic [7:0]  alu_mask_i,
  input  logic [7:0]  alu_flags_i,
  input  logic [15:0] set_i,
  input  logic [15:0] clr_i,
  input  logic [2:0]  grp_clr_i,
  input  logic [3:0]  cc_i,
  output logic [15:0] word_o,
  output logic        carry_o,
  output logic        zero_o,
  output logic        sign_o,
  output logic        pv_o,
  output logic        da_o,
  output logic        hc_o,
  output logic        cc_true_o
);
  logic [WORD_W-1:0] set_vec, clr_vec, word;

  fw_strobe_merge u_merge (
    .set_i     (set_i),
    .clr_i     (clr_i),
    .grp_clr_i (grp_clr_i),
    .set_vec_o (set_vec),
    .clr_vec_o (clr_vec)
  );

  fw_word_reg #(.RESET_WORD(RESET_WORD)) u_reg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_en_i   (load_en_i),
    .load_word_i (load_word_i),
    .alu_mask_i  (alu_mask_i),
    .alu_flags_i (alu_flags_i),
    .set_vec_i   (set_vec),
    .clr_vec_i   (clr_vec),
    .word_o      (word)
  );

  fw_cond_eval u_cond (
    .word_i    (word),
    .cc_i      (cc_i),
    .cc_true_o (cc_true_o)
  );

  assign word_o  = word;
  assign carry_o = word[B_C];
  assign zero_o  = word[B_Z];
  assign sign_o  = word[B_S];
  assign pv_o    = word[B_PV];
  assign da_o    = word[B_DA];
  assign hc_o    = word[B_H];

  a_r9_code8_true: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cc_i == 4'h8) |-> cc_true_o);

  a_r8_code0_false: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cc_i == 4'h0) |-> !cc_true_o);

  a_r8_zero_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cc_i == 4'h6) |-> (cc_true_o == zero_o));

  a_r9_nz_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cc_i == 4'hE) |-> (cc_true_o == !zero_o));
endmodule

// File: tb/flag_word_unit_tb_top.sv
module flag_word_unit_tb_top;
  localparam logic [15:0] RST_W = 16'h4703;
  localparam logic [15:0] USED  = 16'hF8FC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_en = 1'b0;
  logic [15:0] load_word = '0;
  logic [7:0]  alu_mask = '0;
  logic [7:0]  alu_flags = '0;
  logic [15:0] set_s = '0;
  logic [15:0] clr_s = '0;
  logic [2:0]  grp = '0;
  logic [3:0]  cc = '0;
  logic [15:0] word;
  logic        carry, zero, sign, pv, da, hc, cc_true;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  flag_word_unit #(.RESET_WORD(RST_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .load_en_i(load_en), .load_word_i(load_word),
    .alu_mask_i(alu_mask), .alu_flags_i(alu_flags), .set_i(set_s), .clr_i(clr_s),
    .grp_clr_i(grp), .cc_i(cc), .word_o(word), .carry_o(carry), .zero_o(zero),
    .sign_o(sign), .pv_o(pv), .da_o(da), .hc_o(hc), .cc_true_o(cc_true)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    load_en = 1'b0; load_word = '0; alu_mask = '0; alu_flags = '0;
    set_s = '0; clr_s = '0; grp = '0;
  endtask

  // inputs set at posedge+2 are taken at the next posedge; sample 2 after it
  task automatic tick();
    @(posedge clk); #2;
    idle();
  endtask

  task automatic load(input logic [15:0] w);
    load_en = 1'b1; load_word = w; tick();
  endtask

  function automatic bit exp_cc(input logic [3:0] c4, input logic [15:0] w);
    logic c, z, s, v;
    c = w[7]; z = w[6]; s = w[5]; v = w[4];
    case (c4)
      4'd0:  return 1'b0;
      4'd1:  return s ^ v;
      4'd2:  return z | (s ^ v);
      4'd3:  return z | c;
      4'd4:  return v;
      4'd5:  return s;
      4'd6:  return z;
      4'd7:  return c;
      4'd8:  return 1'b1;
      4'd9:  return !(s ^ v);
      4'd10: return !(z | (s ^ v));
      4'd11: return !(z | c);
      4'd12: return !v;
      4'd13: return !s;
      4'd14: return !z;
      default: return !c;
    endcase
  endfunction

  task automatic t_reset();
    chk(word == 16'h4000, "R1 reset value", word, 16'h4000);
    chk((word & ~USED) == 0, "R2 unused after reset", word, word & USED);
  endtask

  task automatic t_load();
    load(16'hFFFF);
    chk(word == 16'hF8FC, "R3 load all ones", word, 16'hF8FC);
    chk((word & 16'h0703) == 0, "R2 unused after load", word, 16'hF8FC);
    load(16'h0703);
    chk(word == 16'h0000, "R2 load unused only", word, 16'h0000);
    load(16'h0000);
    load_en = 1'b1; load_word = 16'h1234; alu_mask = 8'hFF; alu_flags = 8'hFF;
    set_s = 16'hFFFF; grp = 3'd3;
    tick();
    chk(word == (16'h1234 & USED), "R3 load priority", word, 16'h1234 & USED);
  endtask

  task automatic t_alu();
    load(16'h8054);
    alu_mask = 8'hC0; alu_flags = 8'h80;
    tick();
    chk(word == 16'h8094, "R4 alu masked merge", word, 16'h8094);
    alu_mask = 8'h01; alu_flags = 8'h01;
    tick();
    chk(word == 16'h8094, "R4 alu unused bit", word, 16'h8094);
    alu_mask = 8'h04; alu_flags = 8'h00; set_s = 16'hFFFF; clr_s = 16'hFFFF;
    tick();
    chk(word == 16'h8090, "R4 alu over strobes", word, 16'h8090);
  endtask

  task automatic t_strobes();
    load(16'h0000);
    set_s = 16'hA0A4;
    tick();
    chk(word == 16'hA0A4, "R5 set strobes", word, 16'hA0A4);
    clr_s = 16'h2080;
    tick();
    chk(word == 16'h8024, "R5 clear strobes", word, 16'h8024);
    set_s = 16'h0008; clr_s = 16'h0028;
    tick();
    chk(word == 16'h800C, "R5 set wins", word, 16'h800C);
    tick(); tick();
    chk(word == 16'h800C, "R5 hold", word, 16'h800C);
    set_s = 16'h0703;
    tick();
    chk(word == 16'h800C, "R2 set unused", word, 16'h800C);
  endtask

  task automatic t_group();
    logic [15:0] m [8];
    m[0] = 16'h0000; m[1] = 16'h00E0; m[2] = 16'h00F0; m[3] = 16'h00F4;
    m[4] = 16'h0060; m[5] = 16'h0070; m[6] = 16'h0000; m[7] = 16'h0000;
    for (int g = 0; g < 8; g++) begin
      load(16'hFFFF);
      grp = 3'(g);
      tick();
      chk(word == (16'hF8FC & ~m[g]), $sformatf("R6 group code %0d", g), word,
          16'hF8FC & ~m[g]);
    end
  endtask

  task automatic t_flags_map();
    load(16'h0000);
    set_s = 16'h0010;
    tick();
    chk(pv && word == 16'h0010, "R7 shared pv set", word, 16'h0010);
    alu_mask = 8'h10; alu_flags = 8'h00;
    tick();
    chk(!pv && word == 16'h0000, "R7 shared pv clear", word, 16'h0000);
    load(16'h00A8);
    chk({carry, zero, sign, pv, da, hc} == 6'b101010, "R7 flag outputs",
        {10'd0, carry, zero, sign, pv, da, hc}, 16'h002A);
    load(16'h0054);
    chk({carry, zero, sign, pv, da, hc} == 6'b010101, "R7 flag outputs alt",
        {10'd0, carry, zero, sign, pv, da, hc}, 16'h0015);
  endtask

  task automatic t_cond();
    for (int f = 0; f < 64; f++) begin
      logic [15:0] w;
      w = {8'h00, 6'(f), 2'b00};
      load(w);
      for (int k = 0; k < 16; k++) begin
        cc = 4'(k);
        #1;
        chk(cc_true == exp_cc(4'(k), w),
            (k < 8) ? $sformatf("R8 code %0d flags %h", k, w)
                    : $sformatf("R9 code %0d flags %h", k, w),
            {15'd0, cc_true}, {15'd0, exp_cc(4'(k), w)});
      end
    end
  endtask

  task automatic t_cond_timing();
    load(16'h0000);
    cc = 4'h6;
    load_en = 1'b1; load_word = 16'h0040;
    #1;
    chk(cc_true == 1'b0, "R10 before write edge", {15'd0, cc_true}, 16'h0000);
    @(posedge clk); #2; idle();
    chk(cc_true == 1'b1, "R10 after write edge", {15'd0, cc_true}, 16'h0001);
    cc = 4'hE;
    #1;
    chk(cc_true == 1'b0, "R10 follows code", {15'd0, cc_true}, 16'h0000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #2;
    t_reset();
    t_load();
    t_alu();
    t_strobes();
    t_group();
    t_flags_map();
    t_cond();
    t_cond_timing();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0000, 16'h0001);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule